// File: doc/BRIEF.md
# Busy-Bit Scoreboard Issue Controller

This block is the issue and hazard controller of a dynamically scheduled pipeline that has no register renaming. A decoded instruction is offered with a functional-unit class, one destination register and two source registers. The block admits it into a small central window only when no structural or output-dependence hazard exists. Every architectural register has one busy bit, so at most one write to any register can be outstanding at a time.

Waiting entries are released to the functional units out of order. An entry leaves as soon as its operands can be read and its unit can take work, and the oldest eligible entry wins when several qualify. A unit reports completion by returning the window slot number it received at dispatch. The block then grants the register write only when no older instruction still waits to read the previous value of that register, which keeps write-after-read order without renaming. One dispatch and one writeback are granted per cycle.

Top module: `sbIssueCtl`

## Requirements
- R1: After reset every busy bit is clear, `dispValid` and `wbValid` are low, and `issueReady` is high while the requested unit is available.
- R2: An instruction is accepted in a cycle where `inValid` and `issueReady` are both high. It takes the lowest-numbered free window slot, and that slot number is its tag on `dispTag`, `doneTag` and `wbTag`. The busy bit of its destination (bit n of `pendingBits` for register n) reads set from the next cycle on.
- R3: `issueReady` is low while the busy bit of `inDst` is set. It returns high in the cycle after that register's writeback.
- R4: Each window slot stays occupied from acceptance until the cycle of its writeback. With all 4 slots occupied, `issueReady` is low.
- R5: `issueReady` is low when `fuAvail[inFu]` is low.
- R6: A waiting entry is dispatched only when its unit's `fuAvail` bit is high and no older, not yet written-back entry targets one of its sources. A source equal to its own destination does not block it.
- R7: Among dispatch-eligible entries, the oldest one is dispatched. A younger eligible entry passes an older blocked one.
- R8: `wbValid` for a slot rises no earlier than the cycle after its `doneValid`. The slot is freed and the busy bit cleared at the end of the writeback cycle, and a reader that waited on that register is dispatched in the following cycle.
- R9: A finished entry whose destination is a source of an older entry that has not yet been dispatched is held from writeback until that reader is dispatched.
- R10: Among finished entries free of the hold in R9, the oldest writes back first, one per cycle.
- R11: `doneValid` naming a slot that is not executing has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Decoded instruction offered |
| inFu | input | 2 | Functional-unit class of the offered instruction |
| inDst | input | 4 | Destination register |
| inSrcA | input | 4 | First source register |
| inSrcB | input | 4 | Second source register |
| issueReady | output | 1 | Offered instruction can be accepted this cycle |
| fuAvail | input | 3 | Per-unit ability to take work |
| dispValid | output | 1 | An entry is sent to its unit this cycle |
| dispTag | output | 2 | Window slot of the dispatched entry |
| dispFu | output | 2 | Unit class of the dispatched entry |
| dispDst | output | 4 | Destination of the dispatched entry |
| dispSrcA | output | 4 | First source, read this cycle |
| dispSrcB | output | 4 | Second source, read this cycle |
| doneValid | input | 1 | A unit has finished an entry |
| doneTag | input | 2 | Slot of the finished entry |
| wbValid | output | 1 | Result write granted this cycle |
| wbTag | output | 2 | Slot being written back |
| wbDst | output | 4 | Register being written |
| pendingBits | output | 16 | Busy bit per register |

## Verification
A producer followed by a dependent reader shows that a source is held on an older writer and shows the exact cycle spacing from completion through writeback to the reader's release. A second write to a busy register tells the output-dependence stall apart from the window-full stall. A variant whose only source is its own destination shows that an entry is not blocked by itself. A mixed stream with one unit withheld fills the window, lets younger work overtake a blocked older entry, injects a completion for a slot still waiting, and leaves two finished writers held behind an older reader. That last pattern tells the write-after-read hold apart from plain oldest-first writeback ordering.

// File: rtl/sbPkg.sv
package sbPkg;
  parameter int SB_REGS  = 16;
  parameter int SB_DEPTH = 4;
  parameter int SB_FUS   = 3;

  localparam int REG_W = $clog2(SB_REGS);
  localparam int TAG_W = (SB_DEPTH > 1) ? $clog2(SB_DEPTH) : 1;
  localparam int FU_W  = (SB_FUS > 1) ? $clog2(SB_FUS) : 1;
  localparam int CNT_W = $clog2(SB_DEPTH + 1);

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_EXEC = 2'd1,
    ST_DONE = 2'd2
  } stage_e;

  typedef struct packed {
    logic             valid;
    stage_e           stage;
    logic [FU_W-1:0]  fu;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic [TAG_W-1:0] rank;   // 0 = oldest occupied entry
  } winEntry_t;

  typedef struct packed {
    logic             issueEn;
    logic [TAG_W-1:0] issueSlot;
    logic [TAG_W-1:0] issueRank;
    logic             dispEn;
    logic [TAG_W-1:0] dispSlot;
    logic             doneEn;
    logic [TAG_W-1:0] doneSlot;
    logic             wbEn;
    logic [TAG_W-1:0] wbSlot;
  } sbStrobe_t;
endpackage

// File: rtl/sbOldestPick.sv
module sbOldestPick
  import sbPkg::*;
#(
  parameter int N = SB_DEPTH
) (
  input  logic [N-1:0]            elig,
  input  logic [N-1:0][TAG_W-1:0] rank,
  output logic [N-1:0]            pick,
  output logic                    any,
  output logic [TAG_W-1:0]        idx
);
  logic [N-1:0] beaten;

  always_comb begin
    beaten = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (elig[j] && (rank[j] < rank[i])) beaten[i] = 1'b1;
      end
    end
    pick = elig & ~beaten;
  end

  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pick[i]) idx = TAG_W'(i);
    end
  end
endmodule

// File: rtl/sbControl.sv
module sbControl
  import sbPkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  winEntry_t [SB_DEPTH-1:0]       winQ,
  input  logic [SB_REGS-1:0]             pendQ,
  input  logic                           inValid,
  input  logic [FU_W-1:0]                inFu,
  input  logic [REG_W-1:0]               inDst,
  input  logic [SB_FUS-1:0]              fuAvail,
  input  logic                           doneValid,
  input  logic [TAG_W-1:0]               doneTag,
  output logic                           issueReady,
  output sbStrobe_t                      st
);
  logic [CNT_W-1:0]                occCount;
  logic                            freeFound;
  logic [TAG_W-1:0]                freeSlot;
  logic                            fuInFree;
  logic [SB_DEPTH-1:0]             srcBlocked;
  logic [SB_DEPTH-1:0]             warHold;
  logic [SB_DEPTH-1:0]             entryFuFree;
  logic [SB_DEPTH-1:0]             dispElig;
  logic [SB_DEPTH-1:0]             wbElig;
  logic [SB_DEPTH-1:0]             dispPick;
  logic [SB_DEPTH-1:0]             wbPick;
  logic [SB_DEPTH-1:0][TAG_W-1:0]  rankVec;
  logic                            dispAny;
  logic                            wbAny;
  logic [TAG_W-1:0]                dispIdx;
  logic [TAG_W-1:0]                wbIdx;

  // occupancy, lowest free slot, unit availability for the offered op
  always_comb begin
    occCount  = '0;
    freeFound = 1'b0;
    freeSlot  = '0;
    for (int i = 0; i < SB_DEPTH; i++) begin
      if (winQ[i].valid) begin
        occCount = occCount + CNT_W'(1);
      end else if (!freeFound) begin
        freeFound = 1'b1;
        freeSlot  = TAG_W'(i);
      end
    end
    fuInFree = 1'b0;
    for (int k = 0; k < SB_FUS; k++) begin
      if (inFu == FU_W'(k)) fuInFree = fuAvail[k];
    end
  end

  assign issueReady = freeFound && fuInFree && !pendQ[inDst];

  // hazard matrix: older writers block readers, older waiting readers hold writers
  always_comb begin
    srcBlocked  = '0;
    warHold     = '0;
    entryFuFree = '0;
    for (int i = 0; i < SB_DEPTH; i++) begin
      rankVec[i] = winQ[i].rank;
      for (int k = 0; k < SB_FUS; k++) begin
        if (winQ[i].fu == FU_W'(k)) entryFuFree[i] = fuAvail[k];
      end
      for (int j = 0; j < SB_DEPTH; j++) begin
        if (winQ[j].valid && winQ[i].valid && (winQ[j].rank < winQ[i].rank)) begin
          if ((winQ[j].dst == winQ[i].srcA) || (winQ[j].dst == winQ[i].srcB))
            srcBlocked[i] = 1'b1;
          if ((winQ[j].stage == ST_WAIT) &&
              ((winQ[j].srcA == winQ[i].dst) || (winQ[j].srcB == winQ[i].dst)))
            warHold[i] = 1'b1;
        end
      end
      dispElig[i] = winQ[i].valid && (winQ[i].stage == ST_WAIT) &&
                    !srcBlocked[i] && entryFuFree[i];
      wbElig[i]   = winQ[i].valid && (winQ[i].stage == ST_DONE) && !warHold[i];
    end
  end

  sbOldestPick #(.N(SB_DEPTH)) dispPick_i (
    .elig(dispElig), .rank(rankVec), .pick(dispPick), .any(dispAny), .idx(dispIdx)
  );

  sbOldestPick #(.N(SB_DEPTH)) wbPick_i (
    .elig(wbElig), .rank(rankVec), .pick(wbPick), .any(wbAny), .idx(wbIdx)
  );

  always_comb begin
    st.issueEn   = inValid && issueReady;
    st.issueSlot = freeSlot;
    st.issueRank = TAG_W'(occCount - CNT_W'(wbAny));
    st.dispEn    = dispAny;
    st.dispSlot  = dispIdx;
    st.doneEn    = doneValid && winQ[doneTag].valid && (winQ[doneTag].stage == ST_EXEC);
    st.doneSlot  = doneTag;
    st.wbEn      = wbAny;
    st.wbSlot    = wbIdx;
  end

  // R7: the age picker never grants two dispatches
  p_one_dispatch_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dispPick));

  // R10: the age picker never grants two writebacks
  p_one_writeback_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wbPick));

  // R6: a dispatched entry's unit reported it could take work
  p_disp_unit_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.dispEn |-> fuAvail[winQ[st.dispSlot].fu]);
endmodule

// File: rtl/sbDatapath.sv
module sbDatapath
  import sbPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  sbStrobe_t                 st,
  input  logic [FU_W-1:0]           inFu,
  input  logic [REG_W-1:0]          inDst,
  input  logic [REG_W-1:0]          inSrcA,
  input  logic [REG_W-1:0]          inSrcB,
  output winEntry_t [SB_DEPTH-1:0]  winQ,
  output logic [SB_REGS-1:0]        pendQ,
  output logic [FU_W-1:0]           dispFu,
  output logic [REG_W-1:0]          dispDst,
  output logic [REG_W-1:0]          dispSrcA,
  output logic [REG_W-1:0]          dispSrcB,
  output logic [REG_W-1:0]          wbDst
);
  logic [TAG_W-1:0]    freedRank;
  logic [SB_REGS-1:0]  ownedRegs;
  logic [SB_DEPTH-1:0] occVec;

  assign freedRank = winQ[st.wbSlot].rank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winQ  <= '0;
      pendQ <= '0;
    end else begin
      for (int i = 0; i < SB_DEPTH; i++) begin
        if (st.wbEn && (st.wbSlot == TAG_W'(i))) begin
          winQ[i].valid <= 1'b0;
        end else if (winQ[i].valid && st.wbEn && (winQ[i].rank > freedRank)) begin
          winQ[i].rank <= winQ[i].rank - TAG_W'(1);
        end
        if (st.dispEn && (st.dispSlot == TAG_W'(i))) winQ[i].stage <= ST_EXEC;
        if (st.doneEn && (st.doneSlot == TAG_W'(i))) winQ[i].stage <= ST_DONE;
        if (st.issueEn && (st.issueSlot == TAG_W'(i))) begin
          winQ[i].valid <= 1'b1;
          winQ[i].stage <= ST_WAIT;
          winQ[i].fu    <= inFu;
          winQ[i].dst   <= inDst;
          winQ[i].srcA  <= inSrcA;
          winQ[i].srcB  <= inSrcB;
          winQ[i].rank  <= st.issueRank;
        end
      end
      if (st.wbEn)    pendQ[winQ[st.wbSlot].dst] <= 1'b0;
      if (st.issueEn) pendQ[inDst] <= 1'b1;
    end
  end

  assign dispFu   = winQ[st.dispSlot].fu;
  assign dispDst  = winQ[st.dispSlot].dst;
  assign dispSrcA = winQ[st.dispSlot].srcA;
  assign dispSrcB = winQ[st.dispSlot].srcB;
  assign wbDst    = winQ[st.wbSlot].dst;

  // registers claimed by occupied slots, used to cross-check the busy bits
  always_comb begin
    ownedRegs = '0;
    for (int i = 0; i < SB_DEPTH; i++) begin
      occVec[i] = winQ[i].valid;
      if (winQ[i].valid) ownedRegs[winQ[i].dst] = 1'b1;
    end
  end

  // R2: busy bits match exactly the destinations held in the window
  p_busy_matches_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    pendQ == ownedRegs);

  // R3: no second writer of a register enters the window
  p_single_writer_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.issueEn |-> !ownedRegs[inDst]);

  // R4: nothing is accepted into a full window
  p_no_overfill_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.issueEn |-> !(&occVec));

  // R8: a written-back slot is free in the next cycle
  p_slot_freed_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.wbEn |=> !winQ[$past(st.wbSlot)].valid);

  // R11: an accepted completion leaves its slot finished
  p_done_marks_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.doneEn |=> (winQ[$past(st.doneSlot)].stage == ST_DONE));
endmodule

// File: rtl/sbIssueCtl.sv
module sbIssueCtl
  import sbPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [FU_W-1:0]      inFu,
  input  logic [REG_W-1:0]     inDst,
  input  logic [REG_W-1:0]     inSrcA,
  input  logic [REG_W-1:0]     inSrcB,
  output logic                 issueReady,
  input  logic [SB_FUS-1:0]    fuAvail,
  output logic                 dispValid,
  output logic [TAG_W-1:0]     dispTag,
  output logic [FU_W-1:0]      dispFu,
  output logic [REG_W-1:0]     dispDst,
  output logic [REG_W-1:0]     dispSrcA,
  output logic [REG_W-1:0]     dispSrcB,
  input  logic                 doneValid,
  input  logic [TAG_W-1:0]     doneTag,
  output logic                 wbValid,
  output logic [TAG_W-1:0]     wbTag,
  output logic [REG_W-1:0]     wbDst,
  output logic [SB_REGS-1:0]   pendingBits
);
  winEntry_t [SB_DEPTH-1:0] winQ;
  logic [SB_REGS-1:0]       pendQ;
  sbStrobe_t                st;

  sbControl ctl_i (
    .clk(clk), .rstN(rstN), .winQ(winQ), .pendQ(pendQ),
    .inValid(inValid), .inFu(inFu), .inDst(inDst), .fuAvail(fuAvail),
    .doneValid(doneValid), .doneTag(doneTag),
    .issueReady(issueReady), .st(st)
  );

  sbDatapath dp_i (
    .clk(clk), .rstN(rstN), .st(st),
    .inFu(inFu), .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .winQ(winQ), .pendQ(pendQ),
    .dispFu(dispFu), .dispDst(dispDst), .dispSrcA(dispSrcA), .dispSrcB(dispSrcB),
    .wbDst(wbDst)
  );

  assign dispValid   = st.dispEn;
  assign dispTag     = st.dispSlot;
  assign wbValid     = st.wbEn;
  assign wbTag       = st.wbSlot;
  assign pendingBits = pendQ;
endmodule

// File: tb/sbIssueCtl_tb_top.sv
`timescale 1ns/1ps
module sbIssueCtl_tb_top;
  import sbPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [FU_W-1:0] inFu = '0;
  logic [REG_W-1:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic issueReady;
  logic [SB_FUS-1:0] fuAvail = '1;
  logic dispValid;
  logic [TAG_W-1:0] dispTag;
  logic [FU_W-1:0] dispFu;
  logic [REG_W-1:0] dispDst, dispSrcA, dispSrcB;
  logic doneValid = 1'b0;
  logic [TAG_W-1:0] doneTag = '0;
  logic wbValid;
  logic [TAG_W-1:0] wbTag;
  logic [REG_W-1:0] wbDst;
  logic [SB_REGS-1:0] pendingBits;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;
  int dQ[$];
  int wQ[$];

  always #10 clk = ~clk;   // 50 MHz

  sbIssueCtl dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFu(inFu), .inDst(inDst),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .issueReady(issueReady), .fuAvail(fuAvail),
    .dispValid(dispValid), .dispTag(dispTag), .dispFu(dispFu), .dispDst(dispDst),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB), .doneValid(doneValid), .doneTag(doneTag),
    .wbValid(wbValid), .wbTag(wbTag), .wbDst(wbDst), .pendingBits(pendingBits)
  );

  task automatic chk(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    inValid = 1'b0;
    doneValid = 1'b0;
  endtask

  task automatic mid();
    @(negedge clk);
  endtask

  task automatic drv(int fu, int d, int a, int b);
    inValid = 1'b1;
    inFu = FU_W'(fu);
    inDst = REG_W'(d);
    inSrcA = REG_W'(a);
    inSrcB = REG_W'(b);
  endtask

  task automatic fin(int t);
    doneValid = 1'b1;
    doneTag = TAG_W'(t);
  endtask

  // driver side of the scoreboard: expected (tag, register) pairs
  task automatic expD(int t, int d); dQ.push_back(t * 256 + d); endtask
  task automatic expW(int t, int d); wQ.push_back(t * 256 + d); endtask

  // monitor side: pop and compare every dispatch and writeback
  always @(negedge clk) begin
    int e;
    if (rstN && !finished) begin
      if (dispValid) begin
        if (dQ.size() == 0) chk("R7 unexpected dispatch", int'(dispTag) * 256 + int'(dispDst), -1);
        else begin
          e = dQ.pop_front();
          chk("R7 dispatch tag/dst", int'(dispTag) * 256 + int'(dispDst), e);
        end
      end
      if (wbValid) begin
        if (wQ.size() == 0) chk("R10 unexpected writeback", int'(wbTag) * 256 + int'(wbDst), -1);
        else begin
          e = wQ.pop_front();
          chk("R10 writeback tag/dst", int'(wbTag) * 256 + int'(wbDst), e);
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nCmp++; nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    mid();
    chk("R1 busy bits", int'(pendingBits), 0);
    chk("R1 dispValid", int'(dispValid), 0);
    chk("R1 wbValid", int'(wbValid), 0);
    chk("R1 issueReady", int'(issueReady), 1);

    // producer r1 then dependent reader of r1
    tick(); drv(0, 1, 2, 3); expD(0, 1); mid();
    chk("R2 accept", int'(issueReady), 1);
    tick(); drv(1, 4, 1, 5); expD(1, 4); mid();
    tick(); mid();
    chk("R2 busy bits", int'(pendingBits), 16'h0012);
    chk("R6 reader held on older writer", int'(dispValid), 0);
    tick(); fin(0); expW(0, 1); mid();
    chk("R8 no same-cycle writeback", int'(wbValid), 0);
    tick(); mid();
    chk("R8 writeback next cycle", int'(wbValid), 1);
    chk("R8 reader still held", int'(dispValid), 0);
    tick(); mid();
    chk("R8 busy bit cleared", int'(pendingBits), 16'h0010);
    chk("R8 reader released", int'(dispValid), 1);
    tick(); fin(1); expW(1, 4); mid();
    tick(); mid();
    tick(); mid();
    chk("R2 busy bits idle", int'(pendingBits), 0);

    // second writer of r6, then own-destination source
    tick(); drv(0, 6, 7, 7); expD(0, 6); mid();
    chk("R3 first writer accepted", int'(issueReady), 1);
    tick(); drv(1, 6, 6, 0); mid();
    chk("R3 stall on busy dst", int'(issueReady), 0);
    tick(); drv(1, 6, 6, 0); fin(0); expW(0, 6); mid();
    chk("R3 stall while finishing", int'(issueReady), 0);
    tick(); drv(1, 6, 6, 0); mid();
    chk("R3 stall in writeback cycle", int'(issueReady), 0);
    tick(); drv(1, 6, 6, 0); expD(0, 6); mid();
    chk("R3 ready after writeback", int'(issueReady), 1);
    tick(); mid();
    chk("R6 own dst does not block", int'(dispValid), 1);
    tick(); fin(0); expW(0, 6); mid();
    tick(); mid();
    tick(); mid();

    // mixed stream: blocked unit, full window, WAR holds
    tick(); fuAvail = 3'b110; drv(0, 12, 13, 15); mid();
    chk("R5 unit unavailable", int'(issueReady), 0);
    tick(); fuAvail = 3'b111; drv(0, 12, 13, 15); mid();
    chk("R5 unit available", int'(issueReady), 1);
    tick(); fuAvail = 3'b110; drv(1, 13, 14, 14); mid();
    chk("R6 held by unit", int'(dispValid), 0);
    tick(); drv(2, 15, 14, 14); expD(1, 13); mid();
    chk("R7 younger passes blocked older", int'(dispTag), 1);
    tick(); drv(1, 3, 4, 4); expD(2, 15); mid();
    tick(); drv(1, 1, 2, 2); fin(0); expD(3, 3); mid();
    chk("R4 full window stall", int'(issueReady), 0);
    tick(); drv(1, 1, 2, 2); fin(1); mid();
    chk("R11 stray completion ignored", int'(wbValid), 0);
    chk("R4 still full", int'(issueReady), 0);
    tick(); drv(1, 1, 2, 2); fin(2); mid();
    chk("R9 writer held by older reader", int'(wbValid), 0);
    tick(); drv(1, 1, 2, 2); fin(3); mid();
    chk("R9 two writers held", int'(wbValid), 0);
    tick(); drv(1, 1, 2, 2); expW(3, 3); mid();
    chk("R4 full during writeback", int'(issueReady), 0);
    tick(); drv(1, 1, 2, 2); mid();
    chk("R4 ready after free", int'(issueReady), 1);
    chk("R9 hold persists", int'(wbValid), 0);
    tick(); fuAvail = 3'b111; expD(0, 12); expD(3, 1); mid();
    chk("R7 oldest of two eligible", int'(dispTag), 0);
    tick(); expW(1, 13); expW(2, 15); mid();
    chk("R10 oldest writer first", int'(wbTag), 1);
    tick(); fin(3); mid();
    chk("R10 next writer", int'(wbTag), 2);
    tick(); fin(0); expW(3, 1); mid();
    tick(); expW(0, 12); mid();
    tick(); mid();
    tick(); mid();
    chk("R2 busy bits drained", int'(pendingBits), 0);
    chk("R7 dispatch queue empty", dQ.size(), 0);
    chk("R10 writeback queue empty", wQ.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule